// File: doc/BRIEF.md
# Frequency Fallback Watchdog

This block guards a clock-generation subsystem against a hang that follows a bad frequency change. Software writes a depth, counted in units of a slow periodic tick (nominally 250 ms), and then sets the run bit. The block counts down once per tick. If software does not restart or stop it before the count runs out, the block does three things:

- it sets a sticky timeout flag;
- it asks the frequency selector to drop back to a safe code;
- it drives an active-low system reset output low for a fixed number of ticks.

The register side is a set of plain write strobes and read views. There is no streaming data path, so no valid/ready handshake is used.

The readback follows the live state rather than the stored values. The run bit reads 1 only while the countdown is in progress. The depth view shows the live count while running and the stored depth otherwise. The fallback code is picked at expiry from either a software safe code or the power-on strap code, according to a select input. The frequency selector treats the fallback request as the signal to clear its step-less divider mode and reload that code.

Top module: `freq_wdog`

## Requirements
- R1: After reset the block is in its idle state: `run_rd`=0, `depth_rd`=8 (the default depth), `timeout_flag`=0, `rst_out_n`=1 and `fb_req`=0.
- R2: A `ctl_we` cycle with `ctl_en`=1 starts the countdown. From the next cycle, `run_rd`=1 and `depth_rd` shows the stored depth as the live count.
- R3: While running, the live count drops by one on each cycle with `tick`=1 and holds on every other cycle.
- R4: With a stored depth D≥1, expiry happens on the D-th tick after the start. After expiry `run_rd`=0 and `timeout_flag`=1.
- R5: A stored depth of 0 expires on the first tick after the start.
- R6: Writing `ctl_en`=1 again while running reloads the live count from the stored depth.
- R7: Writing `ctl_en`=0 stops the countdown. No later tick causes expiry, `run_rd` reads 0, `depth_rd` shows the stored depth, and `timeout_flag` keeps its value.
- R8: `timeout_flag` clears when a new countdown starts. It never reads 1 while `run_rd` is 1.
- R9: On expiry, `fb_req` is high for exactly one cycle. `rst_out_n` goes low in that same cycle.
- R10: The reset pulse lasts PULSE_TICKS ticks (default 1). `rst_out_n` returns to 1 in the cycle after the PULSE_TICKS-th tick that follows the start of the pulse.
- R11: An expiry while a reset pulse is already in progress still raises `fb_req` but does not lengthen or restart the pulse.
- R12: `fb_code` takes the value of `safe_code` if `safe_sel`=1 at expiry, and of `strap_code` otherwise. It holds that value until the next expiry.
- R13: A depth write while running changes the stored depth but not the live count. The new depth appears on `depth_rd` once the countdown stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick | input | 1 | One-cycle pulse per count unit (250 ms) |
| ctl_we | input | 1 | Write strobe for the run bit |
| ctl_en | input | 1 | Run bit value: 1 start/restart, 0 stop |
| depth_we | input | 1 | Write strobe for the stored depth |
| depth_wdata | input | 7 | Depth value to store |
| safe_sel | input | 1 | 1: fall back to safe_code, 0: to strap_code |
| safe_code | input | 5 | Software safe frequency code |
| strap_code | input | 5 | Power-on latched frequency code |
| run_rd | output | 1 | Live running state |
| depth_rd | output | 7 | Live count while running, stored depth otherwise |
| timeout_flag | output | 1 | Sticky expiry flag |
| fb_req | output | 1 | One-cycle fallback request |
| fb_code | output | 5 | Code to reload on fallback |
| rst_out_n | output | 1 | Active-low system reset pulse |

## Verification
The countdown is tried with several patterns, and each pattern tells a different fault apart:

- A mid-range depth, with idle cycles between ticks, separates tick-driven counting from clock-driven counting and exposes off-by-one expiry.
- A zero depth checks the immediate-expiry corner.
- A restart in mid-count separates reload from resume.
- A stop followed by many ticks shows whether a halted timer can still fire.
- A depth write in mid-count shows whether it leaks into the live count.
- Re-expiry inside a running reset pulse separates a non-retriggering pulse from one that extends.
- Both values of the fallback select confirm which code source is latched.

// File: rtl/freq_wdog_pkg.sv
package freq_wdog_pkg;
  localparam int unsigned DEPTH_W_DEF   = 7;
  localparam int unsigned DEPTH_RST_DEF = 8;
  localparam int unsigned CODE_W_DEF    = 5;

  // Choose the fallback frequency code from the two possible sources.
  function automatic logic [CODE_W_DEF-1:0] pick_code(
    input logic                  use_safe,
    input logic [CODE_W_DEF-1:0] safe_c,
    input logic [CODE_W_DEF-1:0] strap_c
  );
    return use_safe ? safe_c : strap_c;
  endfunction
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned DEPTH_W   = 7,
  parameter int unsigned DEPTH_RST = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               ctl_we,
  input  logic               ctl_en,
  input  logic               depth_we,
  input  logic [DEPTH_W-1:0] depth_wdata,
  output logic               running,
  output logic [DEPTH_W-1:0] depth_view,
  output logic               flag,
  output logic               expire
);
  localparam logic [DEPTH_W-1:0] ONE = DEPTH_W'(1);

  logic [DEPTH_W-1:0] depth_q;
  logic [DEPTH_W-1:0] count_q;
  logic               last_unit;

  // A count of 0 or 1 runs out on the next tick.
  assign last_unit  = (count_q <= ONE);
  assign expire     = running && tick && !ctl_we && last_unit;
  assign depth_view = running ? count_q : depth_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= DEPTH_W'(DEPTH_RST);
    end else if (depth_we) begin
      depth_q <= depth_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      count_q <= '0;
      flag    <= 1'b0;
    end else if (ctl_we) begin
      running <= ctl_en;
      if (ctl_en) begin
        count_q <= depth_q;
        flag    <= 1'b0;
      end
    end else if (running && tick) begin
      if (last_unit) begin
        running <= 1'b0;
        count_q <= '0;
        flag    <= 1'b1;
      end else begin
        count_q <= count_q - ONE;
      end
    end
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int unsigned PULSE_TICKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic fire,
  output logic rst_out_n
);
  localparam int unsigned PW = $clog2(PULSE_TICKS + 1);

  logic [PW-1:0] left_q;
  logic          active;

  assign active    = (left_q != '0);
  assign rst_out_n = !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (active) begin
      // A pulse in progress ignores any new expiry.
      if (tick) left_q <= left_q - PW'(1);
    end else if (fire) begin
      left_q <= PW'(PULSE_TICKS);
    end
  end
endmodule

// File: rtl/wdog_fallback.sv
module wdog_fallback #(
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              safe_sel,
  input  logic [CODE_W-1:0] safe_code,
  input  logic [CODE_W-1:0] strap_code,
  output logic              fb_req,
  output logic [CODE_W-1:0] fb_code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_req  <= 1'b0;
      fb_code <= '0;
    end else begin
      fb_req <= fire;
      if (fire) fb_code <= safe_sel ? safe_code : strap_code;
    end
  end
endmodule

// File: rtl/freq_wdog.sv
module freq_wdog #(
  parameter int unsigned DEPTH_W     = freq_wdog_pkg::DEPTH_W_DEF,
  parameter int unsigned DEPTH_RST   = freq_wdog_pkg::DEPTH_RST_DEF,
  parameter int unsigned CODE_W      = freq_wdog_pkg::CODE_W_DEF,
  parameter int unsigned PULSE_TICKS = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               ctl_we,
  input  logic               ctl_en,
  input  logic               depth_we,
  input  logic [DEPTH_W-1:0] depth_wdata,
  input  logic               safe_sel,
  input  logic [CODE_W-1:0]  safe_code,
  input  logic [CODE_W-1:0]  strap_code,
  output logic               run_rd,
  output logic [DEPTH_W-1:0] depth_rd,
  output logic               timeout_flag,
  output logic               fb_req,
  output logic [CODE_W-1:0]  fb_code,
  output logic               rst_out_n
);
  logic fire;

  wdog_counter #(.DEPTH_W(DEPTH_W), .DEPTH_RST(DEPTH_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .ctl_we(ctl_we), .ctl_en(ctl_en),
    .depth_we(depth_we), .depth_wdata(depth_wdata),
    .running(run_rd), .depth_view(depth_rd),
    .flag(timeout_flag), .expire(fire)
  );

  wdog_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fire(fire),
    .rst_out_n(rst_out_n)
  );

  wdog_fallback #(.CODE_W(CODE_W)) u_fb (
    .clk(clk), .rst_n(rst_n), .fire(fire),
    .safe_sel(safe_sel), .safe_code(safe_code), .strap_code(strap_code),
    .fb_req(fb_req), .fb_code(fb_code)
  );
endmodule

// File: rtl/freq_wdog_chk.sv
module freq_wdog_chk #(
  parameter int unsigned DEPTH_W = 7,
  parameter int unsigned CODE_W  = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               ctl_we,
  input logic               run_rd,
  input logic [DEPTH_W-1:0] depth_rd,
  input logic               timeout_flag,
  input logic               fb_req,
  input logic [CODE_W-1:0]  fb_code,
  input logic               rst_out_n
);
  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_rd && $past(run_rd) && !$past(tick) && !$past(ctl_we)) |-> depth_rd == $past(depth_rd));

  // R4
  expiry_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_req |-> (timeout_flag && !run_rd));

  // R8
  flag_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(timeout_flag && run_rd));

  // R9
  fb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_req |=> !fb_req);

  // R9
  fb_with_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_n) |-> fb_req);

  // R12
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_req |=> (fb_req || $stable(fb_code)));
endmodule

bind freq_wdog freq_wdog_chk #(.DEPTH_W(DEPTH_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ctl_we(ctl_we),
  .run_rd(run_rd), .depth_rd(depth_rd), .timeout_flag(timeout_flag),
  .fb_req(fb_req), .fb_code(fb_code), .rst_out_n(rst_out_n)
);

// File: tb/freq_wdog_tb.sv
module freq_wdog_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       ctl_we = 1'b0;
  logic       ctl_en = 1'b0;
  logic       depth_we = 1'b0;
  logic [6:0] depth_wdata = '0;
  logic       safe_sel = 1'b0;
  logic [4:0] safe_code = '0;
  logic [4:0] strap_code = '0;
  logic       run_rd, timeout_flag, fb_req, rst_out_n;
  logic [6:0] depth_rd;
  logic [4:0] fb_code;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  freq_wdog u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctl_we(ctl_we), .ctl_en(ctl_en),
    .depth_we(depth_we), .depth_wdata(depth_wdata), .safe_sel(safe_sel),
    .safe_code(safe_code), .strap_code(strap_code), .run_rd(run_rd),
    .depth_rd(depth_rd), .timeout_flag(timeout_flag), .fb_req(fb_req),
    .fb_code(fb_code), .rst_out_n(rst_out_n)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_tick();
    tick = 1'b1; step(); tick = 1'b0;
  endtask

  task automatic set_depth(input int d);
    depth_we = 1'b1; depth_wdata = 7'(d); step(); depth_we = 1'b0;
  endtask

  task automatic write_run(input bit v);
    ctl_we = 1'b1; ctl_en = v; step(); ctl_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "run", run_rd, 0);
    chk("R1", "depth", depth_rd, 8);
    chk("R1", "flag", timeout_flag, 0);
    chk("R1", "rst_out_n", rst_out_n, 1);
    chk("R1", "fb_req", fb_req, 0);
  endtask

  task automatic t_count();
    strap_code = 5'h0A; safe_sel = 1'b0; safe_code = 5'h1F;
    set_depth(5);
    write_run(1);
    chk("R2", "run", run_rd, 1);
    chk("R2", "live", depth_rd, 5);
    repeat (3) step();
    chk("R3", "idle hold", depth_rd, 5);
    do_tick();
    chk("R3", "after tick", depth_rd, 4);
    repeat (3) begin do_tick(); step(); end
    chk("R3", "count", depth_rd, 1);
    chk("R4", "not yet", fb_req, 0);
    do_tick();
    chk("R4", "run", run_rd, 0);
    chk("R4", "flag", timeout_flag, 1);
    chk("R9", "fb_req", fb_req, 1);
    chk("R9", "rst low", rst_out_n, 0);
    chk("R12", "strap code", fb_code, 5'h0A);
    step();
    chk("R9", "fb one cycle", fb_req, 0);
    chk("R10", "still low", rst_out_n, 0);
    do_tick();
    chk("R10", "released", rst_out_n, 1);
  endtask

  task automatic t_zero();
    safe_sel = 1'b1; safe_code = 5'h13;
    set_depth(0);
    write_run(1);
    chk("R5", "run", run_rd, 1);
    chk("R8", "flag cleared", timeout_flag, 0);
    step();
    do_tick();
    chk("R5", "fb_req", fb_req, 1);
    chk("R5", "flag", timeout_flag, 1);
    chk("R12", "safe code", fb_code, 5'h13);
    strap_code = 5'h02; safe_code = 5'h04;
    step();
    chk("R12", "code held", fb_code, 5'h13);
    do_tick();
    chk("R10", "released", rst_out_n, 1);
  endtask

  task automatic t_restart();
    set_depth(6);
    write_run(1);
    do_tick(); do_tick();
    chk("R3", "two ticks", depth_rd, 4);
    write_run(1);
    chk("R6", "reload", depth_rd, 6);
    set_depth(2);
    chk("R13", "live kept", depth_rd, 6);
    write_run(0);
    chk("R7", "run", run_rd, 0);
    chk("R13", "stored shown", depth_rd, 2);
    repeat (10) begin
      do_tick();
      if (fb_req) chk("R7", "fired while stopped", 1, 0);
    end
    chk("R7", "rst_out_n", rst_out_n, 1);
    chk("R7", "flag kept", timeout_flag, 0);
  endtask

  task automatic t_noretrig();
    set_depth(0);
    write_run(1);
    do_tick();
    chk("R11", "first pulse", rst_out_n, 0);
    write_run(1);
    do_tick();
    chk("R11", "fb_req again", fb_req, 1);
    chk("R11", "not extended", rst_out_n, 1);
    step();
    chk("R11", "stays high", rst_out_n, 1);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_count();
    t_zero();
    t_restart();
    t_noretrig();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule